// File: doc/BRIEF.md
# Bit-Field and Halfword Insert Unit

This unit packs and unpacks data inside a 32-bit word. Given a destination word, a source word, a field position and a field width, it can zero a field of the destination, copy the low bits of the source into a field of the destination, mirror the whole source word end to end, or write a 16-bit constant into either half of a word. The upper-half write keeps the destination's lower half. The lower-half write zeroes the upper half.

One operation is taken per start pulse. The result, an error flag and a valid strobe are all registered and appear one clock after the pulse. When a field does not fit inside the word, or the operation code is undefined, the error flag goes high and the destination word is returned unchanged. Instruction decode and register-file access are handled elsewhere.

Top module: `bitfield_unit`

## Requirements
- R1: Operation code 0 (field clear) returns the destination with bits lsb through lsb+width-1 forced to zero and every other bit unchanged. For example, lsb 5 and width 4 clear bits 8 down to 5.
- R2: Operation code 1 (field insert) returns the destination with bits lsb through lsb+width-1 replaced by bits width-1 through 0 of the source. Every other bit is unchanged.
- R3: Operation code 2 (reverse) returns a word whose bit 31-n equals bit n of the source, for every n from 0 to 31.
- R4: Operation code 3 (low write) returns the 16-bit immediate in bits 15..0 and zero in bits 31..16.
- R5: Operation code 4 (high write) returns the 16-bit immediate in bits 31..16 and destination bits 15..0 in bits 15..0.
- R6: A field with width 1 to 32 and lsb+width at most 32 is legal. Width 32 at lsb 0 covers the whole word, and width 1 at lsb 31 covers only bit 31.
- R7: For operation codes 0 and 1, a width of 0, a width above 32, or lsb+width above 32 raises the error flag and returns the destination unchanged.
- R8: The error flag is low for legal fields. It is also low for operation codes 2, 3 and 4, whatever the lsb and width inputs hold.
- R9: Operation codes 5, 6 and 7 are undefined. They raise the error flag and return the destination unchanged.
- R10: The valid strobe is high exactly in the cycle after each cycle with start high, and low otherwise. The result and the error flag hold their values in cycles without start.
- R11: After reset, the valid strobe, the error flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts one operation in this cycle |
| op_i | input | 3 | Operation code (0 clear, 1 insert, 2 reverse, 3 low write, 4 high write) |
| dst_i | input | 32 | Destination word |
| src_i | input | 32 | Source word |
| lsb_i | input | 5 | Lowest bit of the field |
| width_i | input | 6 | Field width in bits |
| imm_i | input | 16 | Halfword constant |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | High for one cycle when a result is presented |
| err_o | output | 1 | Registered illegal-field or undefined-operation flag |

## Verification
The cases that are hardest to reach are fields that sit exactly on the legality boundary. These are fields where lsb+width equals 32 or 33, width 32 at lsb 0, and width 0. Uniform random draws rarely produce any of them. Directed cases pin down each boundary. The random phase then draws width and lsb from ranges biased toward the top of the word, so that fields that just fit and fields that just overflow occur often among the ordinary ones.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned WID_W  = POS_W + 1;

  typedef enum logic [2:0] {
    OP_CLEAR  = 3'd0,
    OP_INSERT = 3'd1,
    OP_REV    = 3'd2,
    OP_LOWH   = 3'd3,
    OP_HIGHH  = 3'd4
  } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = $clog2(DW),
  parameter int unsigned WW = PW + 1
) (
  input  logic [PW-1:0] lsb_i,
  input  logic [WW-1:0] width_i,
  output logic [DW-1:0] mask_o,
  output logic          illegal_o
);
  localparam int unsigned SW = WW + 1;

  logic [DW-1:0] ones;
  logic [SW-1:0] span;

  // Thermometer of width ones: bit i set when i < width
  for (genvar i = 0; i < DW; i++) begin : g_therm
    assign ones[i] = (WW'(i) < width_i);
  end

  always_comb begin
    mask_o    = ones << lsb_i;
    span      = SW'(lsb_i) + SW'(width_i);
    illegal_o = (width_i == '0) || (width_i > WW'(DW)) || (span > SW'(DW));
  end
endmodule

// File: rtl/bfu_bit_rev.sv
module bfu_bit_rev #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  for (genvar n = 0; n < DW; n++) begin : g_mirror
    assign dout_o[DW-1-n] = din_i[n];
  end
endmodule

// File: rtl/bfu_field_ops.sv
module bfu_field_ops
  import bfu_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned PW = $clog2(DW),
  parameter int unsigned HW = DW / 2
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [PW-1:0] lsb_i,
  input  logic [DW-1:0] mask_i,
  input  logic          illegal_i,
  input  logic [DW-1:0] rev_i,
  input  logic [HW-1:0] imm_i,
  output logic [DW-1:0] result_o,
  output logic          err_o
);
  logic [DW-1:0] cleared;
  logic [DW-1:0] inserted;

  always_comb begin
    cleared  = dst_i & ~mask_i;
    inserted = cleared | ((src_i << lsb_i) & mask_i);
    result_o = dst_i;
    err_o    = 1'b0;
    case (op_i)
      OP_CLEAR: begin
        err_o    = illegal_i;
        result_o = illegal_i ? dst_i : cleared;
      end
      OP_INSERT: begin
        err_o    = illegal_i;
        result_o = illegal_i ? dst_i : inserted;
      end
      OP_REV:   result_o = rev_i;
      OP_LOWH:  result_o = {{(DW-HW){1'b0}}, imm_i};
      OP_HIGHH: result_o = {imm_i, dst_i[HW-1:0]};
      default: begin
        err_o    = 1'b1;
        result_o = dst_i;
      end
    endcase
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [POS_W-1:0]  lsb_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [HALF_W-1:0] imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DATA_W-1:0] mask;
  logic              illegal;
  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] result_d, result_q;
  logic              err_d, err_q;
  logic              valid_q;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bfu_mask_gen #(.DW(DATA_W), .PW(POS_W), .WW(WID_W)) u_mask (
    .lsb_i     (lsb_i),
    .width_i   (width_i),
    .mask_o    (mask),
    .illegal_o (illegal)
  );

  bfu_bit_rev #(.DW(DATA_W)) u_rev (
    .din_i  (src_i),
    .dout_o (rev)
  );

  bfu_field_ops #(.DW(DATA_W), .PW(POS_W), .HW(HALF_W)) u_ops (
    .op_i      (op_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .lsb_i     (lsb_i),
    .mask_i    (mask),
    .illegal_i (illegal),
    .rev_i     (rev),
    .imm_i     (imm_i),
    .result_o  (result_d),
    .err_o     (err_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result_q <= '0;
      err_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) begin
        result_q <= result_d;
        err_q    <= err_d;
      end
    end
  end

  assign result_o = result_q;
  assign err_o    = err_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk
  import bfu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] src_i,
  input logic [POS_W-1:0]  lsb_i,
  input logic [WID_W-1:0]  width_i,
  input logic [HALF_W-1:0] imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              err_o
);
  function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < DATA_W; k++) r[DATA_W-1-k] = v[k];
    return r;
  endfunction

  logic bad_field;
  assign bad_field = (op_i == OP_CLEAR || op_i == OP_INSERT) &&
                     ((width_i == '0) || (int'(width_i) > DATA_W) ||
                      (int'(lsb_i) + int'(width_i) > DATA_W));

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(result_o) && $stable(err_o)));
  // R3
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_REV) |=> (result_o == mirror($past(src_i)) && !err_o));
  // R5
  high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_HIGHH) |=>
      (result_o == {$past(imm_i), $past(dst_i[HALF_W-1:0])}));
  // R7
  bad_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bad_field) |=> (err_o && result_o == $past(dst_i)));
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i > 3'd4) |=> (err_o && result_o == $past(dst_i)));
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (.*);

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [4:0]  lsb_i = '0;
  logic [5:0]  width_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        valid_o, err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bitfield_unit u_bitfield_unit (.*);

  function automatic bit illegal_m(input logic [2:0] op, input int lsb, input int w);
    if (op > 3'd4) return 1;
    if (op > 3'd1) return 0;
    return (w == 0) || (w > 32) || (lsb + w > 32);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] d,
      input logic [31:0] s, input int lsb, input int w, input logic [15:0] im);
    logic [31:0] r;
    if (illegal_m(op, lsb, w)) return d;
    r = d;
    case (op)
      3'd0: for (int k = lsb; k < lsb + w; k++) r[k] = 1'b0;
      3'd1: for (int k = 0; k < w; k++) r[lsb+k] = s[k];
      3'd2: for (int k = 0; k < 32; k++) r[31-k] = s[k];
      3'd3: r = {16'h0000, im};
      default: r = {im, d[15:0]};
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op, input bit bad);
    if (op > 3'd4) return "R9";
    if (bad) return "R7";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] d, input logic [31:0] s,
      input int lsb, input int w, input logic [15:0] im);
    logic [31:0] e;
    bit bad;
    @(negedge clk);
    start_i = 1'b1; op_i = op; dst_i = d; src_i = s;
    lsb_i = 5'(lsb); width_i = 6'(w); imm_i = im;
    e = model(op, d, s, lsb, w, im);
    bad = illegal_m(op, lsb, w);
    @(negedge clk);
    start_i = 1'b0;
    cmp("R10 valid", 32'(valid_o), 32'd1);
    cmp(req_of(op, bad), result_o, e);
    cmp(bad ? "R7/R9 err" : "R8 err", 32'(err_o), 32'(bad));
    dst_i = ~dst_i; src_i = ~src_i; imm_i = ~imm_i;
    @(negedge clk);
    // R10: no start, strobe low and outputs held
    cmp("R10 idle", 32'(valid_o), 32'd0);
    cmp("R10 hold", result_o, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    cmp("R11 valid", 32'(valid_o), 32'd0);
    cmp("R11 err", 32'(err_o), 32'd0);
    cmp("R11 result", result_o, 32'd0);

    run_op(3'd0, 32'hFFFF_FFFF, 32'h0, 5, 4, 16'h0);     // R1 clears 8..5
    cmp("R1 example", result_o, 32'hFFFF_FE1F);
    run_op(3'd1, 32'h0000_0000, 32'hFFFF_FFF5, 5, 4, 16'h0); // R2
    cmp("R2 example", result_o, 32'h0000_00A0);
    run_op(3'd1, 32'h1234_5678, 32'hCAFE_BABE, 0, 32, 16'h0); // R6 full word
    cmp("R6 full", result_o, 32'hCAFE_BABE);
    run_op(3'd1, 32'h0, 32'h1, 31, 1, 16'h0);               // R6 top bit
    cmp("R6 top", result_o, 32'h8000_0000);
    run_op(3'd0, 32'hFFFF_FFFF, 32'h0, 0, 32, 16'h0);       // R6 clear all
    run_op(3'd0, 32'hDEAD_BEEF, 32'h0, 3, 0, 16'h0);        // R7 width 0
    run_op(3'd1, 32'hDEAD_BEEF, 32'hFFFF, 20, 13, 16'h0);   // R7 33
    run_op(3'd1, 32'hDEAD_BEEF, 32'hFFFF, 0, 40, 16'h0);    // R7 >32
    run_op(3'd1, 32'hDEAD_BEEF, 32'hFFFF, 20, 12, 16'h0);   // R6 exactly 32
    run_op(3'd2, 32'h0, 32'h0000_0001, 31, 0, 16'h0);       // R3 / R8
    cmp("R3 mirror", result_o, 32'h8000_0000);
    run_op(3'd3, 32'hFFFF_FFFF, 32'h0, 31, 63, 16'h5678);   // R4 / R8
    run_op(3'd4, 32'h1111_2222, 32'h0, 30, 0, 16'h1234);    // R5 / R8
    run_op(3'd6, 32'hABCD_EF01, 32'h0, 0, 4, 16'h0);        // R9
    run_op(3'd5, 32'h0BAD_F00D, 32'h0, 0, 4, 16'h0);        // R9
    run_op(3'd7, 32'h7777_0000, 32'h0, 0, 4, 16'h0);        // R9

    void'($urandom(32'd1357));
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      int w = (i % 3 == 0) ? int'($urandom_range(0, 40)) : int'($urandom_range(20, 33));
      int l = (i % 2 == 0) ? int'($urandom_range(0, 31)) : int'($urandom_range(0, 12));
      if (op > 3'd4 && ($urandom & 1)) op = 3'd1;
      run_op(op, $urandom, $urandom, l, w, 16'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule